// File: doc/BRIEF.md
# Multisample Coordinate Interleaver

This block translates a pixel coordinate and a sample index into the position of that sample inside a multisampled surface. The surface stores its samples in a 2x2-pixel interleave, so they are not held contiguously per pixel. The block also gives the position the texture sampler sees for the same sample. Its sampler view spreads each pixel into a 2x2 group.

A second set of inputs takes a surface width and height with a requested sample count. From these the block produces the normalised sample count and the dimensions that must be allocated. Odd dimensions are padded to an even value before the scaling multiply. Without that padding, samples in the last row and column of the interleave would fall outside the allocation.

All paths are combinational. A parameter can add one register stage, which also carries a valid bit. The coordinate mapping is defined only for four samples. For eight samples the block computes the allocation size but does not map coordinates.

Top module: `msaa_interleave`

## Requirements
- R1: The normalised count (`norm_count`) is 0 when the requested count is 0. It is 4 when the request is 1 to 4, and 8 when the request is 5 or more.
- R2: With a normalised count of 4, `alloc_w` = 2 × (width rounded up to even) and `alloc_h` = 2 × (height rounded up to even).
- R3: With a normalised count of 8, `alloc_w` = 4 × (width rounded up to even) and `alloc_h` = 2 × (height rounded up to even). This includes the largest width, 16383, which gives 65536.
- R4: With a normalised count of 0, `alloc_w` and `alloc_h` equal the input width and height unchanged.
- R5: With 4 samples and a sample index of 0 to 3:
  - `phys_x` = 4·⌊x/2⌋ + 2·(s mod 2) + (x mod 2)
  - `phys_y` = 4·⌊y/2⌋ + 2·⌊s/2⌋ + (y mod 2)
- R6: With 4 samples and a sample index of 0 to 3, `log_x` = 2·x + ⌊s/2⌋ and `log_y` = 2·y + (s mod 2).
- R7: With a normalised count of 0, all four coordinate outputs equal (x, y), whatever the sample index, and `sample_err` is 0.
- R8: `sample_err` is 1 in two cases: 4 samples with a sample index of 4 to 7, or a normalised count of 8. In both cases the coordinate outputs pass (x, y) through unchanged.
- R9: With the output register enabled, every output reflects the inputs one clock earlier. `out_valid` follows `in_valid` one cycle later. Reset clears `out_valid` and all outputs.
- R10: For 4 samples, the physical mapping over every pixel and sample of the padded surface is a bijection onto the allocated `alloc_w` × `alloc_h` area.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs are meaningful this cycle |
| x | input | XW (14) | Pixel column |
| y | input | XW (14) | Pixel row |
| sample | input | 3 | Sample index |
| req_count | input | 4 | Requested sample count |
| surf_w | input | XW (14) | Surface width in pixels |
| surf_h | input | XW (14) | Surface height in pixels |
| out_valid | output | 1 | Outputs are meaningful |
| phys_x | output | OW (16) | Column of the sample in memory |
| phys_y | output | OW (16) | Row of the sample in memory |
| log_x | output | OW (16) | Column in the sampler's view |
| log_y | output | OW (16) | Row in the sampler's view |
| sample_err | output | 1 | Sample index or count has no mapping |
| norm_count | output | 4 | Normalised count: 0, 4 or 8 |
| alloc_w | output | SW (17) | Allocated width |
| alloc_h | output | SW (17) | Allocated height |

## Verification
The assertions assume that the output register is present. They also assume that a result is judged only in the cycle after `in_valid` was high, so they compare registered outputs against the inputs one cycle back. The stimulus respects this by changing inputs only between rising edges and holding them for a full cycle. It sweeps small coordinates, every sample index and a spread of requested counts. It also includes odd and even surface sizes and the widest legal width. No request lies outside the 4-bit count or the 14-bit coordinate range.

// File: rtl/msaa_interleave.sv
module msaa_interleave #(
  parameter int XW      = 14,
  parameter int OW      = 16,
  parameter int SW      = XW + 3,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [XW-1:0] x,
  input  logic [XW-1:0] y,
  input  logic [2:0]    sample,
  input  logic [3:0]    req_count,
  input  logic [XW-1:0] surf_w,
  input  logic [XW-1:0] surf_h,
  output logic          out_valid,
  output logic [OW-1:0] phys_x,
  output logic [OW-1:0] phys_y,
  output logic [OW-1:0] log_x,
  output logic [OW-1:0] log_y,
  output logic          sample_err,
  output logic [3:0]    norm_count,
  output logic [SW-1:0] alloc_w,
  output logic [SW-1:0] alloc_h
);

  logic          is4, is8, err_c;
  logic [3:0]    norm_c;
  logic [XW:0]   w_even, h_even;
  logic [SW-1:0] aw_c, ah_c;
  logic [OW-1:0] px_c, py_c, lx_c, ly_c;

  assign is8    = req_count > 4'd4;
  assign is4    = (req_count != 4'd0) && !is8;
  assign norm_c = is8 ? 4'd8 : (is4 ? 4'd4 : 4'd0);
  assign err_c  = is8 | (is4 & sample[2]);

  // pad to the 2x2 block before scaling
  assign w_even = {1'b0, surf_w} + (XW+1)'(surf_w[0]);
  assign h_even = {1'b0, surf_h} + (XW+1)'(surf_h[0]);
  assign aw_c   = is8 ? (SW'(w_even) << 2) : is4 ? (SW'(w_even) << 1) : SW'(surf_w);
  assign ah_c   = (is4 | is8) ? (SW'(h_even) << 1) : SW'(surf_h);

  always_comb begin
    px_c = OW'(x);
    py_c = OW'(y);
    lx_c = OW'(x);
    ly_c = OW'(y);
    if (is4 && !sample[2]) begin
      px_c = OW'({x[XW-1:1], sample[0], x[0]});
      py_c = OW'({y[XW-1:1], sample[1], y[0]});
      lx_c = OW'({x, sample[1]});
      ly_c = OW'({y, sample[0]});
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid  <= 1'b0;
          phys_x     <= '0;
          phys_y     <= '0;
          log_x      <= '0;
          log_y      <= '0;
          sample_err <= 1'b0;
          norm_count <= '0;
          alloc_w    <= '0;
          alloc_h    <= '0;
        end else begin
          out_valid  <= in_valid;
          phys_x     <= px_c;
          phys_y     <= py_c;
          log_x      <= lx_c;
          log_y      <= ly_c;
          sample_err <= err_c;
          norm_count <= norm_c;
          alloc_w    <= aw_c;
          alloc_h    <= ah_c;
        end
      end

      p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      p_valid_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      p_zero_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && req_count == 4'd0) |=> (norm_count == 4'd0));
      p_size_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && norm_count != 4'd0) |-> (alloc_w[1:0] == 2'b00 && alloc_h[1:0] == 2'b00));
      p_passthrough_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && req_count == 4'd0) |=> (alloc_w == SW'($past(surf_w)) && alloc_h == SW'($past(surf_h))));
      p_bad_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && req_count != 4'd0 && req_count <= 4'd4 && sample[2]) |=> sample_err);
      p_quadrant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && req_count != 4'd0 && req_count <= 4'd4 && !sample[2])
          |=> (phys_x[1] == $past(sample[0]) && phys_y[1] == $past(sample[1])));
    end else begin : g_comb
      assign out_valid  = in_valid;
      assign phys_x     = px_c;
      assign phys_y     = py_c;
      assign log_x      = lx_c;
      assign log_y      = ly_c;
      assign sample_err = err_c;
      assign norm_count = norm_c;
      assign alloc_w    = aw_c;
      assign alloc_h    = ah_c;
    end
  endgenerate

endmodule

// File: tb/msaa_interleave_bench.sv
`timescale 1ns/1ps
module msaa_interleave_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [13:0] x = '0, y = '0, surf_w = '0, surf_h = '0;
  logic [2:0]  sample = '0;
  logic [3:0]  req_count = '0;
  logic        out_valid, sample_err;
  logic [15:0] phys_x, phys_y, log_x, log_y;
  logic [3:0]  norm_count;
  logic [16:0] alloc_w, alloc_h;

  int checks = 0;
  int fails = 0;
  bit hits [0:127];

  always #4 clk = ~clk;

  msaa_interleave u_msaa_interleave (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x(x), .y(y),
    .sample(sample), .req_count(req_count), .surf_w(surf_w), .surf_h(surf_h),
    .out_valid(out_valid), .phys_x(phys_x), .phys_y(phys_y), .log_x(log_x),
    .log_y(log_y), .sample_err(sample_err), .norm_count(norm_count),
    .alloc_w(alloc_w), .alloc_h(alloc_h)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int norm_of(input int r);
    return (r == 0) ? 0 : (r <= 4) ? 4 : 8;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9 reset valid", int'(out_valid), 0);
    check(alloc_w == '0 && phys_x == '0, "R9 reset data", int'(alloc_w), 0);
    rst_n = 1'b1;
    step();

    // size sweep (R1 R2 R3 R4)
    in_valid = 1'b1;
    for (int r = 0; r < 10; r++)
      for (int w = 0; w < 10; w++)
        for (int h = 0; h < 10; h++) begin
          int n, ew, eh, aw, ah;
          req_count = 4'(r); surf_w = 14'(w); surf_h = 14'(h);
          step();
          n = norm_of(r);
          ew = w + (w % 2); eh = h + (h % 2);
          aw = (n == 0) ? w : (n == 4) ? ew * 2 : ew * 4;
          ah = (n == 0) ? h : eh * 2;
          check(int'(norm_count) == n, "R1 norm", int'(norm_count), n);
          if (n == 4) begin
            check(int'(alloc_w) == aw, "R2 width", int'(alloc_w), aw);
            check(int'(alloc_h) == ah, "R2 height", int'(alloc_h), ah);
          end else if (n == 8) begin
            check(int'(alloc_w) == aw, "R3 width", int'(alloc_w), aw);
            check(int'(alloc_h) == ah, "R3 height", int'(alloc_h), ah);
          end else begin
            check(int'(alloc_w) == aw, "R4 width", int'(alloc_w), aw);
            check(int'(alloc_h) == ah, "R4 height", int'(alloc_h), ah);
          end
        end
    req_count = 4'd15; surf_w = 14'd16383; surf_h = 14'd16383;
    step();
    check(int'(alloc_w) == 65536, "R3 max width", int'(alloc_w), 65536);
    check(int'(alloc_h) == 32768, "R3 max height", int'(alloc_h), 32768);

    // coordinate sweep (R5 R6 R7 R8)
    for (int ri = 0; ri < 4; ri++)
      for (int xi = 0; xi < 6; xi++)
        for (int yi = 0; yi < 6; yi++)
          for (int s = 0; s < 8; s++) begin
            int r, n, ex, ey, lx, ly;
            bit ee;
            r = (ri == 0) ? 0 : (ri == 1) ? 2 : (ri == 2) ? 4 : 7;
            n = norm_of(r);
            req_count = 4'(r); x = 14'(xi + 8190 * (ri % 2)); y = 14'(yi); sample = 3'(s);
            step();
            ee = (n == 8) || (n == 4 && s > 3);
            if (n == 4 && s < 4) begin
              ex = 4 * (int'(x) / 2) + 2 * (s % 2) + (int'(x) % 2);
              ey = 4 * (yi / 2) + 2 * (s / 2) + (yi % 2);
              lx = 2 * int'(x) + s / 2;
              ly = 2 * yi + s % 2;
              check(int'(phys_x) == ex, "R5 phys_x", int'(phys_x), ex);
              check(int'(phys_y) == ey, "R5 phys_y", int'(phys_y), ey);
              check(int'(log_x) == lx, "R6 log_x", int'(log_x), lx);
              check(int'(log_y) == ly, "R6 log_y", int'(log_y), ly);
            end else begin
              check(int'(phys_x) == int'(x) && int'(log_x) == int'(x), n == 0 ? "R7 pass x" : "R8 pass x", int'(phys_x), int'(x));
              check(int'(phys_y) == yi && int'(log_y) == yi, n == 0 ? "R7 pass y" : "R8 pass y", int'(phys_y), yi);
            end
            check(sample_err == ee, n == 0 ? "R7 err" : "R8 err", int'(sample_err), int'(ee));
          end

    // bijection over padded 5x3 surface (R10)
    begin
      int cnt;
      cnt = 0;
      for (int i = 0; i < 128; i++) hits[i] = 1'b0;
      req_count = 4'd4; surf_w = 14'd5; surf_h = 14'd3;
      for (int xi = 0; xi < 6; xi++)
        for (int yi = 0; yi < 4; yi++)
          for (int s = 0; s < 4; s++) begin
            x = 14'(xi); y = 14'(yi); sample = 3'(s);
            step();
            if (int'(phys_x) < int'(alloc_w) && int'(phys_y) < int'(alloc_h) && int'(alloc_w) == 12) begin
              if (!hits[int'(phys_y) * 12 + int'(phys_x)]) cnt++;
              hits[int'(phys_y) * 12 + int'(phys_x)] = 1'b1;
            end else
              check(1'b0, "R10 out of range", int'(phys_x), int'(alloc_w));
          end
      check(cnt == 96, "R10 distinct cells", cnt, 96);
    end

    // valid drop (R9)
    in_valid = 1'b0;
    step();
    check(out_valid == 1'b0, "R9 valid low", int'(out_valid), 0);
    in_valid = 1'b1;
    step();
    check(out_valid == 1'b1, "R9 valid high", int'(out_valid), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule